// File: doc/BRIEF.md
# DS1 Test Pattern Generator

This block produces a serial stream of DS1 test data, one bit per clock enable. A select input picks the sequence. The choices are the constant patterns, a group of short sparse patterns and a QRSS sequence whose zero runs are limited. There are also two long octet-built stress patterns with sections of different density, a group of channel patterns built from repeated octets, and four plain maximal-length pseudorandom sequences. A test set sits in front of the framer and line coder and takes the bit on each cycle in which it raises the enable.

The select is read only when a restart strobe is given. A restart moves the chosen sequence back to its first bit and reloads all shift registers. A flag marks the first bit of each repetition, so a receiver or a frame aligner can lock to the pattern boundary. The output bit is combinational from the held state. The bit shown during an enabled cycle is the bit sent, and the next bit appears after that clock edge.

Top module: `tpg_top`

## Requirements
- R1: A synchronous reset selects code 0 (constant one), puts the position at the first bit, and drives `bit_out`=1 and `first_bit`=1 in the first cycle after reset.
- R2: The state moves one bit per cycle with `bit_en`=1 and `restart`=0. With `bit_en`=0 the outputs hold.
- R3: `restart` loads `pat_sel`, returns to the first bit and reloads the shift registers, and takes precedence over `bit_en` in the same cycle.
- R4: A change of `pat_sel` without `restart` has no effect on the output stream.
- R5: Short patterns are sent MSB first, with positions numbered from 1. Code 2 is 24 bits with ones at positions 2, 6 and 22. Code 3 is 8 bits with a one at position 1. Code 4 is 8 bits with ones at 2 and 7. Code 5 is 8 bits with a one at 5. Code 6 is 16 bits with a one at position 1.
- R6: Code 7 (QRSS) runs a 20-stage register with feedback from stages 20 and 17, seeded with all ones. It emits stage 20, forced to 1 after 14 emitted zeros in a row. The period is 1,048,575 bits.
- R7: Code 8 is 96 octets: 48×FFh, 4×AAh, 160 bits of a one followed by fifteen zeros repeating, 4×AAh, and again 160 bits of that run pattern.
- R8: Code 9 is 120 octets: 72×FFh, 4×AAh, 20×10h, 4×AAh, 20×10h.
- R9: The channel patterns are as follows. Code 10 is 100×FFh then 100×00h. Code 11 is 100×7Eh then 100×00h. Code 12 is 16×4Ch. Code 13 is 16×40h. Code 14 is 7×FEh then FFh.
- R10: Codes 15, 16, 17 and 18 are maximal-length sequences with (stages, tap) of (11,9), (15,14), (20,3) and (23,18). Each is seeded with all ones, emits its last stage and has no zero forcing.
- R11: `first_bit` is 1 exactly on the first bit of each repetition. The constant patterns and unused codes repeat every 8 bits.
- R12: Code 0 sends constant one. Code 1 and codes 19 to 31 send constant zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Consume the current bit and step to the next |
| restart | input | 1 | Load `pat_sel` and go to the first bit |
| pat_sel | input | 5 | Pattern code, sampled on `restart` |
| bit_out | output | 1 | Current pattern bit |
| first_bit | output | 1 | Current bit is the first of a repetition |

## Verification
A restart and a bit enable can fall in the same cycle, and so can a restart and the wrap of the position counter. Every pattern is started with both strobes high together. Later restarts are issued while the enable is also toggling at random. The run is correct only if the next bit is the first bit of the newly selected pattern, with the flag raised. The behavioural model, which rebuilds every pattern as a bit queue or as a linear recurrence, must agree with the design on every clock.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int SEL_W = 5;
    localparam int PW    = 23;

    typedef enum logic [SEL_W-1:0] {
        PAT_ONES    = 5'd0,
        PAT_ZEROS   = 5'd1,
        PAT_3IN24   = 5'd2,
        PAT_1IN8    = 5'd3,
        PAT_2IN8    = 5'd4,
        PAT_PULSE   = 5'd5,
        PAT_1IN16   = 5'd6,
        PAT_QRSS    = 5'd7,
        PAT_STRESSA = 5'd8,
        PAT_STRESSB = 5'd9,
        PAT_CH1     = 5'd10,
        PAT_CH2     = 5'd11,
        PAT_CH3     = 5'd12,
        PAT_CH4     = 5'd13,
        PAT_CH6     = 5'd14,
        PAT_PRBS11  = 5'd15,
        PAT_PRBS15  = 5'd16,
        PAT_PRBS20  = 5'd17,
        PAT_PRBS23  = 5'd18
    } pat_e;

    function automatic logic is_lfsr(input logic [SEL_W-1:0] s);
        return (s == PAT_QRSS) || (s == PAT_PRBS11) || (s == PAT_PRBS15) ||
               (s == PAT_PRBS20) || (s == PAT_PRBS23);
    endfunction

    function automatic logic [PW-1:0] pat_len(input logic [SEL_W-1:0] s);
        case (s)
            PAT_3IN24:              return PW'(24);
            PAT_1IN16:              return PW'(16);
            PAT_QRSS, PAT_PRBS20:   return PW'(1048575);
            PAT_STRESSA:            return PW'(768);
            PAT_STRESSB:            return PW'(960);
            PAT_CH1, PAT_CH2:       return PW'(1600);
            PAT_CH3, PAT_CH4:       return PW'(128);
            PAT_CH6:                return PW'(64);
            PAT_PRBS11:             return PW'(2047);
            PAT_PRBS15:             return PW'(32767);
            PAT_PRBS23:             return PW'(8388607);
            default:                return PW'(8);
        endcase
    endfunction

    function automatic logic obit(input logic [7:0] v, input logic [2:0] b);
        return v[3'd7 - b];
    endfunction

    function automatic logic fixed_bit(input logic [SEL_W-1:0] s, input logic [PW-1:0] pos);
        logic [PW-4:0] oct;
        logic [2:0]    b;
        logic          run;
        oct = pos[PW-1:3];
        b   = pos[2:0];
        run = (pos[3:0] == 4'd0);
        case (s)
            PAT_ONES:    return 1'b1;
            PAT_3IN24:   return (pos == PW'(1)) || (pos == PW'(5)) || (pos == PW'(21));
            PAT_1IN8:    return obit(8'h80, b);
            PAT_2IN8:    return obit(8'h42, b);
            PAT_PULSE:   return obit(8'h08, b);
            PAT_1IN16:   return run;
            PAT_STRESSA: begin
                if (oct < 48)      return 1'b1;
                else if (oct < 52) return obit(8'hAA, b);
                else if (oct < 72) return run;
                else if (oct < 76) return obit(8'hAA, b);
                else               return run;
            end
            PAT_STRESSB: begin
                if (oct < 72)       return 1'b1;
                else if (oct < 76)  return obit(8'hAA, b);
                else if (oct < 96)  return obit(8'h10, b);
                else if (oct < 100) return obit(8'hAA, b);
                else                return obit(8'h10, b);
            end
            PAT_CH1:     return (oct < 100) ? 1'b1 : 1'b0;
            PAT_CH2:     return (oct < 100) ? obit(8'h7E, b) : 1'b0;
            PAT_CH3:     return obit(8'h4C, b);
            PAT_CH4:     return obit(8'h40, b);
            PAT_CH6:     return (oct < 7) ? obit(8'hFE, b) : 1'b1;
            default:     return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tpg_seq.sv
module tpg_seq
    import tpg_pkg::*;
#(
    parameter int W = PW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         adv,
    input  logic [W-1:0] len,
    output logic [W-1:0] pos
);

    always_ff @(posedge clk) begin
        if (rst || load)
            pos <= '0;
        else if (adv)
            pos <= (pos == len - W'(1)) ? '0 : pos + W'(1);
    end

endmodule

// File: rtl/tpg_prbs.sv
module tpg_prbs
    import tpg_pkg::*;
#(
    parameter int LW   = 23,
    parameter int ZMAX = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             adv,
    input  logic [SEL_W-1:0] kind,
    output logic             bit_o
);

    localparam int IW = $clog2(LW + 1);
    localparam int ZW = $clog2(ZMAX + 1);

    logic [LW-1:0] sr, sr_nxt, mask;
    logic [IW-1:0] n, t;
    logic [ZW-1:0] zrun;
    logic          raw, fb, force_one;

    always_comb begin
        case (kind)
            PAT_PRBS11: begin n = IW'(11); t = IW'(9);  end
            PAT_PRBS15: begin n = IW'(15); t = IW'(14); end
            PAT_QRSS:   begin n = IW'(20); t = IW'(17); end
            PAT_PRBS20: begin n = IW'(20); t = IW'(3);  end
            default:    begin n = IW'(23); t = IW'(18); end
        endcase
        raw       = sr[n - IW'(1)];
        fb        = sr[n - IW'(1)] ^ sr[t - IW'(1)];
        mask      = (LW'(1) << n) - LW'(1);
        sr_nxt    = ((sr << 1) | LW'(fb)) & mask;
        force_one = (kind == PAT_QRSS) && (zrun == ZW'(ZMAX));
        bit_o     = raw | force_one;
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            sr   <= '1;
            zrun <= '0;
        end else if (adv) begin
            sr <= sr_nxt;
            if (kind == PAT_QRSS)
                zrun <= bit_o ? '0 : zrun + ZW'(1);
        end
    end

endmodule

// File: rtl/tpg_top.sv
module tpg_top
    import tpg_pkg::*;
#(
    parameter int LFSR_W = 23,
    parameter int ZMAX   = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             restart,
    input  logic [SEL_W-1:0] pat_sel,
    output logic             bit_out,
    output logic             first_bit
);

    logic [SEL_W-1:0] sel_q;
    logic [PW-1:0]    pos;
    logic             adv, lfsr_bit;

    assign adv = bit_en && !restart;

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= PAT_ONES;
        else if (restart)
            sel_q <= pat_sel;
    end

    tpg_seq #(.W(PW)) u_seq (
        .clk (clk),
        .rst (rst),
        .load(restart),
        .adv (adv),
        .len (pat_len(sel_q)),
        .pos (pos)
    );

    tpg_prbs #(.LW(LFSR_W), .ZMAX(ZMAX)) u_prbs (
        .clk  (clk),
        .rst  (rst),
        .load (restart),
        .adv  (adv),
        .kind (sel_q),
        .bit_o(lfsr_bit)
    );

    assign bit_out   = is_lfsr(sel_q) ? lfsr_bit : fixed_bit(sel_q, pos);
    assign first_bit = (pos == '0);

endmodule

// File: rtl/tpg_chk.sv
module tpg_chk
    import tpg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bit_en,
    input logic             restart,
    input logic             bit_out,
    input logic             first_bit,
    input logic [SEL_W-1:0] sel_q
);

    logic [4:0] zc;

    always_ff @(posedge clk) begin
        if (rst || restart)
            zc <= '0;
        else if (bit_en && sel_q == PAT_QRSS)
            zc <= bit_out ? 5'd0 : zc + 5'd1;
        else if (sel_q != PAT_QRSS)
            zc <= '0;
    end

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (bit_out && first_bit)); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) (!bit_en && !restart) |=> ($stable(bit_out) && $stable(first_bit))); // R2
    AST_RESTART_FIRST: assert property (@(posedge clk) disable iff (rst) restart |=> first_bit); // R3
    AST_ZERO_RUN: assert property (@(posedge clk) disable iff (rst) zc <= 5'd14); // R6
    AST_SPARSE_LEAD: assert property (@(posedge clk) disable iff (rst) (sel_q == PAT_1IN8 && first_bit) |-> bit_out); // R5
    AST_ZEROS_CONST: assert property (@(posedge clk) disable iff (rst) (sel_q == PAT_ZEROS) |-> !bit_out); // R12

endmodule

bind tpg_top tpg_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .restart  (restart),
    .bit_out  (bit_out),
    .first_bit(first_bit),
    .sel_q    (sel_q)
);

// File: tb/tpg_top_tb.sv
module tpg_top_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       restart = 1'b0;
    logic [4:0] pat_sel = 5'd0;
    logic       bit_out, first_bit;

    always #5 clk = ~clk;

    tpg_top u_dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .restart(restart),
        .pat_sel(pat_sel), .bit_out(bit_out), .first_bit(first_bit)
    );

    int    vectors = 0;
    int    miscompares = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string tag = "R1";

    // reference model state
    int msel, mpos, mlen, ln, lt, mzr;
    bit mlfsr;
    bit pq[$];
    bit lq[$];

    task automatic push_oct(input bit [7:0] v, input int count);
        for (int k = 0; k < count; k++)
            for (int j = 7; j >= 0; j--) pq.push_back(v[j]);
    endtask

    task automatic push_runs(input int count);
        for (int k = 0; k < count; k++)
            for (int j = 0; j < 16; j++) pq.push_back(j == 0);
    endtask

    task automatic push_pos(input int length, input int a, input int b, input int c);
        for (int i = 1; i <= length; i++) pq.push_back(i == a || i == b || i == c);
    endtask

    task automatic use_lfsr(input int n, input int t);
        mlfsr = 1'b1; ln = n; lt = t;
        for (int i = 0; i < n; i++) lq.push_back(1'b1);
    endtask

    task automatic model_restart(input int s);
        msel = s; mpos = 0; mzr = 0; mlfsr = 1'b0;
        pq.delete(); lq.delete();
        case (s)
            0:  push_oct(8'hFF, 1);
            2:  push_pos(24, 2, 6, 22);
            3:  push_pos(8, 1, 0, 0);
            4:  push_pos(8, 2, 7, 0);
            5:  push_pos(8, 5, 0, 0);
            6:  push_pos(16, 1, 0, 0);
            7:  use_lfsr(20, 17);
            8:  begin push_oct(8'hFF, 48); push_oct(8'hAA, 4); push_runs(10);
                      push_oct(8'hAA, 4); push_runs(10); end
            9:  begin push_oct(8'hFF, 72); push_oct(8'hAA, 4); push_oct(8'h10, 20);
                      push_oct(8'hAA, 4); push_oct(8'h10, 20); end
            10: begin push_oct(8'hFF, 100); push_oct(8'h00, 100); end
            11: begin push_oct(8'h7E, 100); push_oct(8'h00, 100); end
            12: push_oct(8'h4C, 16);
            13: push_oct(8'h40, 16);
            14: begin push_oct(8'hFE, 7); push_oct(8'hFF, 1); end
            15: use_lfsr(11, 9);
            16: use_lfsr(15, 14);
            17: use_lfsr(20, 3);
            18: use_lfsr(23, 18);
            default: push_oct(8'h00, 1);
        endcase
        mlen = mlfsr ? ((1 << ln) - 1) : pq.size();
    endtask

    function automatic bit exp_bit();
        if (mlfsr) begin
            if (msel == 7 && mzr >= 14) return 1'b1;
            return lq[0];
        end
        return pq[mpos];
    endfunction

    task automatic model_adv();
        bit b;
        b = exp_bit();
        if (mlfsr) begin
            if (msel == 7) mzr = b ? 0 : mzr + 1;
            lq.push_back(lq[0] ^ lq[ln - lt]);
            void'(lq.pop_front());
        end
        mpos = (mpos + 1 == mlen) ? 0 : mpos + 1;
    endtask

    task automatic compare();
        bit e, ef;
        e  = exp_bit();
        ef = (mpos == 0);
        vectors++;
        if (bit_out !== e || first_bit !== ef) begin
            miscompares++;
            $display("FAIL %s sel=%0d pos=%0d: bit_out=%b first_bit=%b expected %b %b",
                     tag, msel, mpos, bit_out, first_bit, e, ef);
        end
    endtask

    task automatic step(input bit en, input bit rs, input int sel);
        compare();
        bit_en = en; restart = rs; pat_sel = 5'(sel);
        if (rs) model_restart(sel);
        else if (en) model_adv();
        @(negedge clk);
    endtask

    // restart with bit_en also high (R3), then random enables; select noise half way (R4)
    task automatic run_pat(input int sel, input int n, input int pct, input string t);
        tag = t;
        step(1'b1, 1'b1, sel);
        for (int i = 0; i < n; i++)
            step($urandom_range(99) < pct, 1'b0, (i < n / 2) ? sel : (sel + 3) % 32);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 195000 && !done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        model_restart(0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tag = "R1";
        step(1'b0, 1'b0, 9);
        tag = "R2";
        for (int i = 0; i < 20; i++) step(i % 3 == 0, 1'b0, 9);

        run_pat(1,  40,   80, "R12");
        run_pat(0,  40,   80, "R12");
        run_pat(25, 40,   80, "R12");
        run_pat(2,  200,  75, "R5");
        run_pat(3,  100,  75, "R5");
        run_pat(4,  100,  75, "R5");
        run_pat(5,  100,  75, "R5");
        run_pat(6,  150,  75, "R5");
        run_pat(8,  2000, 90, "R7");
        run_pat(9,  2500, 90, "R8");
        run_pat(10, 3800, 90, "R9");
        run_pat(11, 3800, 90, "R9");
        run_pat(12, 400,  70, "R9");
        run_pat(13, 400,  70, "R9");
        run_pat(14, 300,  70, "R9");
        run_pat(7,  70000, 100, "R6");
        run_pat(15, 5000, 100, "R10");
        run_pat(16, 4000, 90, "R10");
        run_pat(17, 4000, 90, "R10");
        run_pat(18, 4000, 90, "R10");

        // restart storm mixed with enables and counter wraps (R3, R11)
        tag = "R3";
        for (int i = 0; i < 600; i++)
            step($urandom_range(1), $urandom_range(19) == 0, (i % 15) + 2);
        tag = "R11";
        run_pat(3, 64, 100, "R11");

        // reset in mid pattern (R1)
        run_pat(9, 100, 100, "R8");
        tag = "R1";
        rst = 1'b1; bit_en = 1'b1;
        @(negedge clk);
        rst = 1'b0; bit_en = 1'b0;
        model_restart(0);
        step(1'b1, 1'b0, 4);
        step(1'b0, 1'b0, 4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule